// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller for a dual-slope integrating analog-to-digital converter. It drives three analog switch controls that select auto-zero, signal integration and reference deintegration. During deintegration it counts clocks until the external comparator changes state, and that count becomes the conversion magnitude. It also takes the sign from the comparator and flags an overrange. The integrator and comparator are outside the block; only the comparator level `comp_i` enters.

With `run_i` high, conversions repeat on a fixed cycle of 2^(CNT_W+1) clocks. Signal integration takes 2^CNT_W clocks. Deintegration takes up to 2^CNT_W - 8 clocks, and auto-zero fills the rest of the cycle. With `run_i` low, the conversion in progress finishes. The sequencer then parks in auto-zero 7 clocks before integration would start, so a restart always takes the same short time. Reset places the sequencer at that parked point.

Each result comes out as a one-clock `valid_o` pulse, together with `mag_o`, `sign_o` and `ovr_o`. The result stream has no ready input, because an integrating converter cannot pause mid-slope. A consumer must capture the result on the pulse. The result stays on the outputs until the next pulse overwrites it. `busy_o` lets external circuits synchronize to the measuring part of the cycle. CNT_W must be at least 4.

Top module: `dual_slope_seq`

## Requirements
- R1: After reset the outputs are as follows: `sel_az_o`=1, `sel_int_o`=0, `sel_de_o`=0, `busy_o`=0, `valid_o`=0, `mag_o`=0, `sign_o`=0 and `ovr_o`=0. The sequencer sits at the parked point, 7 clocks before integration.
- R2: While `run_i` stays high, successive starts of integration are exactly 2^(CNT_W+1) clocks apart, whatever the result.
- R3: Integration (`sel_int_o`=1) lasts exactly 2^CNT_W clocks, and deintegration (`sel_de_o`=1) follows on the next clock.
- R4: `sign_o` reports the level of `comp_i` on the last integration clock. This holds even when the magnitude is zero.
- R5: Let k be the number of deintegration clocks on which `comp_i` still equals the sampled sign before it first differs. The result is then `mag_o`=k and `ovr_o`=0, for k from 0 to 2^CNT_W - 9.
- R6: If `comp_i` does not change during 2^CNT_W - 8 deintegration clocks, the result is `ovr_o`=1 with `mag_o` all ones.
- R7: `valid_o` is high for exactly one clock, and on that clock the new result is already on `mag_o`, `sign_o` and `ovr_o`. In the same clock the phase switches back to auto-zero, and the result holds until the next pulse.
- R8: `busy_o` is high exactly while integrating or deintegrating, and falls in the cycle in which `valid_o` pulses.
- R9: When `run_i` goes low during a conversion, that conversion completes and reports its result. The sequencer then stays in auto-zero with no further integration for as long as `run_i` stays low.
- R10: `run_i` is sampled only at the parked point. When `run_i` is high at the parked point, integration starts exactly 7 clocks later.
- R11: Exactly one of `sel_az_o`, `sel_int_o`, `sel_de_o` is high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | 1 = convert continuously, 0 = stop after the current conversion |
| comp_i | input | 1 | Comparator level from the integrator |
| sel_az_o | output | 1 | Auto-zero switch select |
| sel_int_o | output | 1 | Signal-integrate switch select |
| sel_de_o | output | 1 | Reference-deintegrate switch select |
| busy_o | output | 1 | Status: high during integration and deintegration |
| valid_o | output | 1 | One-clock strobe for a new result |
| mag_o | output | CNT_W | Magnitude count |
| sign_o | output | 1 | Sign (comparator level at end of integration) |
| ovr_o | output | 1 | Overrange flag |

## Verification
The bench runs the block with a small width and plays the comparator as an integrator would. It holds the comparator at a chosen level through integration, then flips it after a chosen number of deintegration clocks. The patterns are a flip at the first clock with either sign, a flip at a mid count, a flip at the last legal clock, and no flip at all. Together they separate an off-by-one count, a lost sign at zero magnitude, a late overrange decision and a fixed-period fault. A run/hold pattern then drops `run_i` mid-conversion and raises it again after a long park. This shows whether the conversion in progress completes, whether the sequencer truly stays parked, and whether the restart takes exactly 7 clocks.

// File: rtl/dss_pkg.sv
package dss_pkg;
  typedef enum logic [1:0] {
    PH_AZ  = 2'd0,
    PH_INT = 2'd1,
    PH_DE  = 2'd2
  } phase_e;
endpackage

// File: rtl/dss_cycle_timer.sv
// Position within the conversion cycle; frozen while parked.
module dss_cycle_timer #(
  parameter int              POS_W = 17,
  parameter logic [POS_W-1:0] START = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             freeze_i,
  output logic [POS_W-1:0] pos_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pos_o <= START;
    else if (!freeze_i) pos_o <= pos_o + 1'b1;
  end

  // R9: a parked sequencer does not move
  a_r9_park_holds: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_i |=> pos_o == $past(pos_o));
  // R2: the cycle wraps to its start after the last position
  a_r2_cycle_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze_i && (&pos_o)) |=> pos_o == '0);
endmodule

// File: rtl/dss_deint_counter.sv
// Counts deintegration clocks; flags the last legal count.
module dss_deint_counter #(
  parameter int CNT_W  = 16,
  parameter int DE_MAX = (1 << CNT_W) - 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DE_MAX - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (en_i)   cnt_o <= cnt_o + 1'b1;
  end

  assign full_o = (cnt_o == LAST);

  // R6: while counting, the count never passes the deintegration window
  a_r6_count_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> cnt_o <= LAST);
endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             comp_i,
  output logic             sel_az_o,
  output logic             sel_int_o,
  output logic             sel_de_o,
  output logic             busy_o,
  output logic             valid_o,
  output logic [CNT_W-1:0] mag_o,
  output logic             sign_o,
  output logic             ovr_o
);
  import dss_pkg::*;

  localparam int               POS_W    = CNT_W + 1;
  localparam int               DE_MAX   = (1 << CNT_W) - 8;
  localparam logic [POS_W-1:0] CYC_LAST = {POS_W{1'b1}};
  localparam logic [POS_W-1:0] INT_LAST = POS_W'((1 << CNT_W) - 1);
  localparam logic [POS_W-1:0] PARK     = CYC_LAST - POS_W'(6);

  phase_e           phase;
  logic [POS_W-1:0] pos;
  logic [CNT_W-1:0] cnt;
  logic             full;
  logic             pol_q;
  logic             freeze;
  logic             flip;

  assign freeze = (phase == PH_AZ) && (pos == PARK) && !run_i;
  assign flip   = (phase == PH_DE) && (comp_i != pol_q);

  dss_cycle_timer #(.POS_W(POS_W), .START(PARK)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .freeze_i (freeze),
    .pos_o    (pos)
  );

  dss_deint_counter #(.CNT_W(CNT_W), .DE_MAX(DE_MAX)) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (phase == PH_INT),
    .en_i   (phase == PH_DE),
    .cnt_o  (cnt),
    .full_o (full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_AZ;
      pol_q   <= 1'b0;
      valid_o <= 1'b0;
      mag_o   <= '0;
      sign_o  <= 1'b0;
      ovr_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      unique case (phase)
        PH_AZ: begin
          if (pos == CYC_LAST) phase <= PH_INT;
        end
        PH_INT: begin
          if (pos == INT_LAST) begin
            pol_q <= comp_i;
            phase <= PH_DE;
          end
        end
        PH_DE: begin
          if (flip) begin
            mag_o   <= cnt;
            ovr_o   <= 1'b0;
            sign_o  <= pol_q;
            valid_o <= 1'b1;
            phase   <= PH_AZ;
          end else if (full) begin
            mag_o   <= '1;
            ovr_o   <= 1'b1;
            sign_o  <= pol_q;
            valid_o <= 1'b1;
            phase   <= PH_AZ;
          end
        end
        default: phase <= PH_AZ;
      endcase
    end
  end

  assign sel_az_o  = (phase == PH_AZ);
  assign sel_int_o = (phase == PH_INT);
  assign sel_de_o  = (phase == PH_DE);
  assign busy_o    = sel_int_o || sel_de_o;

  // R7: strobe lasts one clock
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  // R7: the strobe coincides with the return to auto-zero
  a_r7_latch_in_az: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> sel_az_o);
  // R6: an overrange result carries a saturated magnitude
  a_r6_ovr_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && ovr_o) |-> (&mag_o));
  // R8: status ends only with a latch strobe
  a_r8_busy_ends_at_latch: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> valid_o);
  // R3: integration always begins at cycle position zero
  a_r3_int_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_int_o) |-> pos == '0);
  // R11: exactly one switch select active
  a_r11_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({sel_az_o, sel_int_o, sel_de_o}));
endmodule

// File: tb/sim_dual_slope_seq.sv
module sim_dual_slope_seq;
  localparam int W      = 5;
  localparam int CYC    = 1 << (W + 1);
  localparam int INTLEN = 1 << W;
  localparam int DEMAX  = (1 << W) - 8;
  localparam int ONES   = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         run_i = 1'b1;
  logic         comp_i = 1'b0;
  logic         sel_az_o, sel_int_o, sel_de_o, busy_o, valid_o, sign_o, ovr_o;
  logic [W-1:0] mag_o;

  int checks = 0;
  int fails  = 0;
  longint last_int_t = 0;

  always #5 clk = ~clk;

  dual_slope_seq #(.CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .comp_i(comp_i),
    .sel_az_o(sel_az_o), .sel_int_o(sel_int_o), .sel_de_o(sel_de_o),
    .busy_o(busy_o), .valid_o(valid_o), .mag_o(mag_o),
    .sign_o(sign_o), .ovr_o(ovr_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Counts falling edges until integration is seen to start.
  task automatic wait_int_start(output int n);
    logic prev;
    prev = sel_int_o;
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (sel_int_o && !prev) break;
      prev = sel_int_o;
    end
  endtask

  // Called on the falling edge where integration was first seen.
  // k < 0 keeps the comparator steady (overrange).
  task automatic do_conv(input bit p, input int k, input int exp_mag,
                         input bit exp_ovr, input string tag);
    int ilen;
    int nv;
    comp_i = p;
    ilen = 1;
    @(negedge clk);
    while (sel_int_o) begin
      ilen++;
      @(negedge clk);
    end
    chk(ilen == INTLEN, {"R3 int length ", tag}, ilen, INTLEN);
    chk(sel_de_o && busy_o, {"R3 deint follows ", tag}, int'(sel_de_o), 1);
    if (k >= 0) begin
      repeat (k) @(negedge clk);
      comp_i = ~p;
    end
    nv = 0;
    do begin
      @(negedge clk);
      nv++;
    end while (!valid_o && nv < 2 * INTLEN);
    if (k < 0) chk(nv == DEMAX, {"R6 deint window ", tag}, nv, DEMAX);
    chk(valid_o == 1'b1, {"R7 strobe ", tag}, int'(valid_o), 1);
    chk(int'(mag_o) == exp_mag, {"R5/R6 magnitude ", tag}, int'(mag_o), exp_mag);
    chk(sign_o == p, {"R4 sign ", tag}, int'(sign_o), int'(p));
    chk(ovr_o == exp_ovr, {"R6 overrange ", tag}, int'(ovr_o), int'(exp_ovr));
    chk(!busy_o && sel_az_o, {"R8 busy falls with strobe ", tag}, int'(busy_o), 0);
    @(negedge clk);
    chk(!valid_o, {"R7 one-clock strobe ", tag}, int'(valid_o), 0);
    chk(int'(mag_o) == exp_mag, {"R7 result held ", tag}, int'(mag_o), exp_mag);
  endtask

  // Next integration start, checking the fixed cycle length.
  task automatic next_int_periodic(input string tag);
    int n;
    wait_int_start(n);
    chk(($time - last_int_t) / 10 == CYC, {"R2 period ", tag},
        int'(($time - last_int_t) / 10), CYC);
    last_int_t = $time;
  endtask

  task automatic t_reset_and_start();
    int n;
    repeat (3) @(negedge clk);
    chk(sel_az_o && !sel_int_o && !sel_de_o, "R1 select state", int'(sel_az_o), 1);
    chk(!busy_o && !valid_o, "R1 status/strobe", int'(busy_o) + int'(valid_o), 0);
    chk(mag_o == '0 && !sign_o && !ovr_o, "R1 result zero", int'(mag_o), 0);
    rst_n = 1'b1;
    wait_int_start(n);
    chk(n == 7, "R1/R10 first integrate after reset", n, 7);
    last_int_t = $time;
  endtask

  task automatic t_hold_and_restart();
    int n;
    bit bad;
    wait_int_start(n);
    run_i = 1'b0;
    do_conv(1'b1, 3, 3, 1'b0, "hold mid-conversion R9");
    bad = 1'b0;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (!sel_az_o || sel_int_o || busy_o) bad = 1'b1;
    end
    chk(!bad, "R9 parked in auto-zero", int'(bad), 0);
    run_i = 1'b1;
    wait_int_start(n);
    chk(n == 7, "R10 restart latency", n, 7);
    last_int_t = $time;
    do_conv(1'b0, 2, 2, 1'b0, "after restart R10");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset_and_start();
    do_conv(1'b1, 5, 5, 1'b0, "mid count");
    next_int_periodic("a");
    do_conv(1'b0, 0, 0, 1'b0, "zero negative-low R4");
    next_int_periodic("b");
    do_conv(1'b1, 0, 0, 1'b0, "zero high R4");
    next_int_periodic("c");
    do_conv(1'b0, DEMAX - 1, DEMAX - 1, 1'b0, "last legal count");
    next_int_periodic("d");
    do_conv(1'b1, -1, ONES, 1'b1, "overrange high");
    next_int_periodic("e");
    do_conv(1'b0, -1, ONES, 1'b1, "overrange low");
    next_int_periodic("f");
    do_conv(1'b1, 1, 1, 1'b0, "count one");
    t_hold_and_restart();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule